// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block keeps track of the power mode a chip runs in and moves between run, wait and stop modes on request. Software programs it through a byte-wide register port with four registers: a permission register that can be written once, a mode control register, a deep-stop submode register and a read-only one-hot status register. A sleep request input is qualified by a deep-sleep input. An interrupt input wakes the system, and a debug-enable input changes what the status shows. The regulators and clock gates that really change the power are outside the block. They follow the one-hot mode code on `mode_stat`.

A stop request first runs through a short entry window of `WIN_CYC` cycles. An interrupt during that window cancels the entry, sets a sticky abort flag and leaves the system in the mode it came from. Mode requests that the permission register has not allowed are dropped without any side effect. A wake from a low-power mode either returns to normal run or stays in low-power run. The choice follows a policy bit and also depends on the mode the stop was entered from.

Register offsets: 0 permission, 1 control, 2 submode, 3 status. The control register reads as {wake policy bit 7, run field [6:5], 0 at bit 4, abort flag bit 3, stop field [2:0]}.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: The permission register (offset 0) resets to 0x00. It holds allow bits 1 (deep stop), 3 (leakage stop) and 5 (low-power run, wait and stop); all other bits read 0. Only the first write after reset takes effect, and that write also clears the stop field to 000.
- R2: The stop field, control bits [2:0], uses these codes: 000 normal stop (always allowed), 010 low-power stop (needs allow bit 5), 011 leakage stop (needs bit 3) and 100 deep stop (needs bit 1). A write of a code that is not allowed, or of a reserved code 001/101/110/111, leaves the field unchanged. The other fields of that write are still applied.
- R3: The run field, control bits [6:5], uses 00 for normal run and 10 for low-power run. The code 10 is accepted only when allow bit 5 is set and the current mode is normal run; the codes 01 and 11 are dropped. The mode follows the field one cycle after the write. Writing 00 while in low-power run returns the system to normal run.
- R4: A `sleep_req` pulse with `sleep_deep` high, given in normal or low-power run, starts a stop entry of `WIN_CYC` cycles and clears the abort flag (control bit 3). The status shows the origin mode for the whole entry and then shows the target mode. From normal run the target is the mode in the stop field. From low-power run, both codes 000 and 010 lead to low-power stop.
- R5: If `irq` is high in any cycle of the entry window, the abort flag is set to 1 and the system returns to its origin mode.
- R6: An interrupt in normal stop, leakage stop or deep stop returns the system to normal run. In low-power wait, an interrupt leads to normal run if control bit 7 is 1 and to low-power run if it is 0. In low-power run with bit 7 set, an interrupt leads to normal run. Every return to normal run clears the run field to 00. A `sleep_req` with `sleep_deep` low, given in low-power run, enters low-power wait.
- R7: Low-power stop entered from normal run always wakes to normal run. Entered from low-power run, it wakes according to control bit 7.
- R8: The status value, read at offset 3 and on `mode_stat`, is one-hot and resets to 0x01. The bits mean: bit 0 normal run, bit 1 normal stop, bit 2 low-power run, bit 3 low-power wait, bit 4 low-power stop, bit 5 leakage stop, bit 6 deep stop.
- R9: While `dbg_en` is high, the status does not change to the normal-stop or low-power-stop code; it keeps its previous value. All other codes update as usual.
- R10: The submode register (offset 2) resets to 0x03. Bits [2:0] select submode 0 to 3, and writes of codes 100 to 111 leave them unchanged. Bit 5, the brown-out-off option, is always stored. All other bits read 0.
- R11: `reg_rdata` shows the register selected by `reg_addr` one cycle later. Writes to offset 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| sleep_req | input | 1 | Sleep request pulse |
| sleep_deep | input | 1 | Deep-sleep qualifier |
| irq | input | 1 | Interrupt (wake / abort) |
| dbg_en | input | 1 | Debug active |
| mode_stat | output | 7 | One-hot current mode code |

## Verification
The assertions check the following on every cycle:
- the status is one-hot;
- the permission register never changes after its first write;
- the stop field only ever holds an allowed code;
- the run field moves to low-power run only from normal run with permission;
- an interrupt in the entry window returns the system to its origin and sets the abort flag;
- debug mode never shows the two hidden stop codes;
- both wake policies behave as specified.

Only the bench scenarios can show the rest: the exact cycle in which a stop entry completes or aborts, the dependence of the wake target on the mode a stop was entered from, and the masking of register readback.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int REG_AW = 2;
  localparam int REG_DW = 8;
  localparam int STAT_W = 7;

  typedef enum logic [2:0] {
    M_RUN, M_STOP, M_LPRUN, M_LPWAIT, M_LPSTOP, M_LKSTOP, M_DEEPSTOP, M_ENTRY
  } pmode_e;

  localparam logic [2:0] SS_NORM = 3'b000;
  localparam logic [2:0] SS_LP   = 3'b010;
  localparam logic [2:0] SS_LEAK = 3'b011;
  localparam logic [2:0] SS_DEEP = 3'b100;
  localparam logic [1:0] RS_NORM = 2'b00;
  localparam logic [1:0] RS_LP   = 2'b10;

  localparam logic [REG_AW-1:0] A_PERM = 2'd0;
  localparam logic [REG_AW-1:0] A_CTRL = 2'd1;
  localparam logic [REG_AW-1:0] A_SUB  = 2'd2;
  localparam logic [REG_AW-1:0] A_STAT = 2'd3;

  localparam int PB_DEEP = 1;
  localparam int PB_LEAK = 3;
  localparam int PB_LP   = 5;

  function automatic logic [STAT_W-1:0] mode_hot(pmode_e m);
    logic [STAT_W-1:0] h;
    h = '0;
    case (m)
      M_RUN:      h[0] = 1'b1;
      M_STOP:     h[1] = 1'b1;
      M_LPRUN:    h[2] = 1'b1;
      M_LPWAIT:   h[3] = 1'b1;
      M_LPSTOP:   h[4] = 1'b1;
      M_LKSTOP:   h[5] = 1'b1;
      M_DEEPSTOP: h[6] = 1'b1;
      default:    h = '0;
    endcase
    return h;
  endfunction
endpackage

// File: rtl/pmc_regs.sv
module pmc_regs
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic              cur_run,
  input  logic              clr_run_sel,
  input  logic              stop_abort,
  input  logic [STAT_W-1:0] stat,
  output logic [REG_DW-1:0] rdata,
  output logic [2:0]        stop_sel,
  output logic [1:0]        run_sel,
  output logic              wake_run
);
  localparam logic [REG_DW-1:0] PERM_MASK = REG_DW'(8'h2A);
  localparam logic [2:0]        SUB_RST   = 3'b011;

  logic [REG_DW-1:0] perm_q;
  logic              perm_done;
  logic [2:0]        sub_q;
  logic              sub_bo;
  logic              stop_ok, run_ok;
  logic [REG_DW-1:0] rd_n;

  always_comb begin
    case (wdata[2:0])
      SS_NORM: stop_ok = 1'b1;
      SS_LP:   stop_ok = perm_q[PB_LP];
      SS_LEAK: stop_ok = perm_q[PB_LEAK];
      SS_DEEP: stop_ok = perm_q[PB_DEEP];
      default: stop_ok = 1'b0;
    endcase
    case (wdata[6:5])
      RS_NORM: run_ok = 1'b1;
      RS_LP:   run_ok = perm_q[PB_LP] && cur_run;
      default: run_ok = 1'b0;
    endcase
  end

  always_comb begin
    rd_n = '0;
    case (addr)
      A_PERM: rd_n = perm_q;
      A_CTRL: rd_n[7:0] = {wake_run, run_sel, 1'b0, stop_abort, stop_sel};
      A_SUB:  rd_n[7:0] = {2'b00, sub_bo, 2'b00, sub_q};
      default: rd_n[STAT_W-1:0] = stat;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      perm_q    <= '0;
      perm_done <= 1'b0;
      stop_sel  <= SS_NORM;
      run_sel   <= RS_NORM;
      wake_run  <= 1'b0;
      sub_q     <= SUB_RST;
      sub_bo    <= 1'b0;
      rdata     <= '0;
    end else begin
      if (clr_run_sel) run_sel <= RS_NORM;
      if (we) begin
        case (addr)
          A_PERM: if (!perm_done) begin
            perm_q    <= wdata & PERM_MASK;
            perm_done <= 1'b1;
            stop_sel  <= SS_NORM;
          end
          A_CTRL: begin
            if (stop_ok) stop_sel <= wdata[2:0];
            if (run_ok)  run_sel  <= wdata[6:5];
            wake_run <= wdata[7];
          end
          A_SUB: begin
            if (!wdata[2]) sub_q <= wdata[2:0];
            sub_bo <= wdata[5];
          end
          default: ;
        endcase
      end
      rdata <= rd_n;
    end
  end

  AST_PERM_ONCE: assert property (@(posedge clk) disable iff (rst)
    perm_done |=> $stable(perm_q)); // R1
  AST_PERM_CLR_STOP: assert property (@(posedge clk) disable iff (rst)
    $rose(perm_done) |-> (stop_sel == SS_NORM)); // R1
  AST_STOP_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (stop_sel == SS_NORM) || (stop_sel == SS_LP && perm_q[PB_LP]) ||
    (stop_sel == SS_LEAK && perm_q[PB_LEAK]) || (stop_sel == SS_DEEP && perm_q[PB_DEEP])); // R2
  AST_LPRUN_GATE: assert property (@(posedge clk) disable iff (rst)
    (run_sel != RS_LP) |=> (run_sel != RS_LP) || $past(cur_run && perm_q[PB_LP])); // R3
  AST_SUB_LEGAL: assert property (@(posedge clk) disable iff (rst)
    !sub_q[2]); // R10
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
#(
  parameter int WIN_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_req,
  input  logic              sleep_deep,
  input  logic              irq,
  input  logic              dbg_en,
  input  logic [2:0]        stop_sel,
  input  logic [1:0]        run_sel,
  input  logic              wake_run,
  output logic [STAT_W-1:0] stat_q,
  output logic              stop_abort,
  output logic              cur_run,
  output logic              clr_run_sel
);
  localparam int CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

  pmode_e state, state_n, origin_q, tgt_q, tgt_n, visible;
  logic [CW-1:0] cnt_q;
  logic from_run;
  logic start, abort, hold;

  always_comb begin
    if (state == M_RUN) begin
      case (stop_sel)
        SS_LP:   tgt_n = M_LPSTOP;
        SS_LEAK: tgt_n = M_LKSTOP;
        SS_DEEP: tgt_n = M_DEEPSTOP;
        default: tgt_n = M_STOP;
      endcase
    end else begin
      case (stop_sel)
        SS_LEAK: tgt_n = M_LKSTOP;
        SS_DEEP: tgt_n = M_DEEPSTOP;
        default: tgt_n = M_LPSTOP;
      endcase
    end
  end

  always_comb begin
    state_n = state;
    start   = 1'b0;
    abort   = 1'b0;
    case (state)
      M_RUN: begin
        if (run_sel == RS_LP) state_n = M_LPRUN;
        else if (sleep_req && sleep_deep) begin state_n = M_ENTRY; start = 1'b1; end
      end
      M_LPRUN: begin
        if (irq && wake_run) state_n = M_RUN;
        else if (sleep_req && sleep_deep) begin state_n = M_ENTRY; start = 1'b1; end
        else if (sleep_req) state_n = M_LPWAIT;
        else if (run_sel == RS_NORM) state_n = M_RUN;
      end
      M_LPWAIT: if (irq) state_n = wake_run ? M_RUN : M_LPRUN;
      M_LPSTOP: if (irq) state_n = (from_run || wake_run) ? M_RUN : M_LPRUN;
      M_ENTRY: begin
        if (irq) begin abort = 1'b1; state_n = origin_q; end
        else if (cnt_q == LAST) state_n = tgt_q;
      end
      default: if (irq) state_n = M_RUN;
    endcase
  end

  always_comb begin
    if (state_n == M_ENTRY) visible = start ? state : origin_q;
    else                    visible = state_n;
    hold = dbg_en && (visible == M_STOP || visible == M_LPSTOP);
  end

  assign cur_run     = (state == M_RUN);
  assign clr_run_sel = (state_n == M_RUN) && (state != M_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= M_RUN;
      origin_q   <= M_RUN;
      tgt_q      <= M_STOP;
      cnt_q      <= '0;
      from_run   <= 1'b0;
      stop_abort <= 1'b0;
      stat_q     <= mode_hot(M_RUN);
    end else begin
      state <= state_n;
      if (start) begin
        origin_q   <= state;
        tgt_q      <= tgt_n;
        from_run   <= (state == M_RUN);
        cnt_q      <= '0;
        stop_abort <= 1'b0;
      end else if (state == M_ENTRY) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (abort) stop_abort <= 1'b1;
      if (!hold) stat_q <= mode_hot(visible);
    end
  end

  AST_STAT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(stat_q) == 1); // R8
  AST_ABORT_RETURN: assert property (@(posedge clk) disable iff (rst)
    (state == M_ENTRY && irq) |=> (stop_abort && state != M_ENTRY && state == $past(origin_q))); // R5
  AST_WAIT_WAKE: assert property (@(posedge clk) disable iff (rst)
    (state == M_LPWAIT && irq && !wake_run) |=> (state == M_LPRUN)); // R6
  AST_LPSTOP_RUN: assert property (@(posedge clk) disable iff (rst)
    (state == M_LPSTOP && from_run && irq) |=> (state == M_RUN)); // R7
  AST_DBG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dbg_en && !stat_q[1] && !stat_q[4]) |=> (!stat_q[1] && !stat_q[4])); // R9
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int WIN_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              sleep_req,
  input  logic              sleep_deep,
  input  logic              irq,
  input  logic              dbg_en,
  output logic [STAT_W-1:0] mode_stat
);
  logic [2:0] stop_sel;
  logic [1:0] run_sel;
  logic       wake_run, stop_abort, cur_run, clr_run_sel;

  pmc_regs u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .cur_run(cur_run), .clr_run_sel(clr_run_sel), .stop_abort(stop_abort),
    .stat(mode_stat), .rdata(reg_rdata), .stop_sel(stop_sel),
    .run_sel(run_sel), .wake_run(wake_run)
  );

  pmc_fsm #(.WIN_CYC(WIN_CYC)) u_fsm (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .sleep_deep(sleep_deep),
    .irq(irq), .dbg_en(dbg_en), .stop_sel(stop_sel), .run_sel(run_sel),
    .wake_run(wake_run), .stat_q(mode_stat), .stop_abort(stop_abort),
    .cur_run(cur_run), .clr_run_sel(clr_run_sel)
  );
endmodule

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic sleep_req = 1'b0, sleep_deep = 1'b0, irq = 1'b0, dbg_en = 1'b0;
  logic [6:0] mode_stat;
  int total = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pwr_mode_ctrl uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sleep_req(sleep_req),
    .sleep_deep(sleep_deep), .irq(irq), .dbg_en(dbg_en), .mode_stat(mode_stat)
  );

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sleep_req = 0; sleep_deep = 0; irq = 0; dbg_en = 0; reg_we = 0;
    cyc(2);
    rst = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic sleep_pulse(logic deep);
    @(negedge clk);
    sleep_req = 1'b1; sleep_deep = deep;
    @(posedge clk);
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  task automatic irq_pulse();
    @(negedge clk);
    irq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    irq = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    chk("R8 reset mode_stat", {1'b0, mode_stat}, 8'h01);
    rd(2'd0, d); chk("R1 perm reset", d, 8'h00);
    rd(2'd1, d); chk("R11 ctrl reset", d, 8'h00);
    rd(2'd2, d); chk("R10 sub reset", d, 8'h03);
    rd(2'd3, d); chk("R8 status reset", d, 8'h01);
  endtask

  task automatic t_perm();
    logic [7:0] d;
    do_reset();
    wr(2'd1, 8'h02); rd(2'd1, d); chk("R2 unpermitted stop code dropped", d, 8'h00);
    wr(2'd1, 8'h40); cyc(2);
    rd(2'd1, d); chk("R3 low-power run needs permission", d, 8'h00);
    chk("R3 mode stays normal run", {1'b0, mode_stat}, 8'h01);
    wr(2'd0, 8'hFF); rd(2'd0, d); chk("R1 perm masked", d, 8'h2A);
    rd(2'd1, d); chk("R1 stop field after perm write", d, 8'h00);
    wr(2'd0, 8'h00); rd(2'd0, d); chk("R1 second write ignored", d, 8'h2A);
    wr(2'd3, 8'h10); rd(2'd3, d); chk("R11 status write ignored", d, 8'h01);
  endtask

  task automatic t_stop_codes();
    logic [7:0] d;
    do_reset();
    wr(2'd0, 8'h20);
    wr(2'd1, 8'h03); rd(2'd1, d); chk("R2 leak stop not allowed", d, 8'h00);
    wr(2'd1, 8'h04); rd(2'd1, d); chk("R2 deep stop not allowed", d, 8'h00);
    wr(2'd1, 8'h82); rd(2'd1, d); chk("R2 low-power stop allowed", d, 8'h82);
    do_reset();
    wr(2'd0, 8'h0A);
    wr(2'd1, 8'h03); rd(2'd1, d); chk("R2 leak stop allowed", d, 8'h03);
    wr(2'd1, 8'h81); rd(2'd1, d); chk("R2 reserved dropped, wake bit kept", d, 8'h83);
    wr(2'd1, 8'h07); rd(2'd1, d); chk("R2 reserved 111 dropped", d, 8'h03);
    wr(2'd1, 8'h04); rd(2'd1, d); chk("R2 deep stop code", d, 8'h04);
  endtask

  task automatic t_run();
    logic [7:0] d;
    do_reset();
    wr(2'd0, 8'h20);
    wr(2'd1, 8'h60); rd(2'd1, d); chk("R3 reserved run code dropped", d, 8'h00);
    wr(2'd1, 8'h40); cyc(1);
    chk("R3 low-power run entered", {1'b0, mode_stat}, 8'h04);
    rd(2'd3, d); chk("R8 status low-power run", d, 8'h04);
    wr(2'd1, 8'h00); cyc(1);
    chk("R3 back to normal run", {1'b0, mode_stat}, 8'h01);
  endtask

  task automatic t_entry();
    logic [7:0] d;
    do_reset();
    wr(2'd0, 8'h2A);
    wr(2'd1, 8'h03);
    sleep_pulse(1'b1);
    chk("R4 entry cycle 1 shows origin", {1'b0, mode_stat}, 8'h01);
    cyc(1);
    chk("R4 entry cycle 2 shows origin", {1'b0, mode_stat}, 8'h01);
    cyc(1);
    chk("R4 leak stop reached", {1'b0, mode_stat}, 8'h20);
    rd(2'd1, d); chk("R4 abort flag clear", d, 8'h03);
    irq_pulse();
    chk("R6 leak stop wakes to run", {1'b0, mode_stat}, 8'h01);
    wr(2'd1, 8'h04); sleep_pulse(1'b1); cyc(3);
    chk("R4 deep stop reached", {1'b0, mode_stat}, 8'h40);
    irq_pulse();
    chk("R6 deep stop wakes to run", {1'b0, mode_stat}, 8'h01);
  endtask

  task automatic t_abort();
    logic [7:0] d;
    do_reset();
    wr(2'd0, 8'h2A);
    sleep_pulse(1'b1);
    irq = 1'b1; @(posedge clk); @(negedge clk); irq = 1'b0;
    chk("R5 abort first cycle stays run", {1'b0, mode_stat}, 8'h01);
    rd(2'd1, d); chk("R5 abort flag set", d, 8'h08);
    sleep_pulse(1'b1); cyc(2);
    chk("R4 normal stop reached", {1'b0, mode_stat}, 8'h02);
    rd(2'd1, d); chk("R4 abort flag cleared on start", d, 8'h00);
    irq_pulse();
    chk("R6 normal stop wakes to run", {1'b0, mode_stat}, 8'h01);
    sleep_pulse(1'b1); cyc(1);
    irq = 1'b1; @(posedge clk); @(negedge clk); irq = 1'b0;
    chk("R5 abort second cycle stays run", {1'b0, mode_stat}, 8'h01);
    rd(2'd1, d); chk("R5 abort flag set again", d, 8'h08);
    cyc(3);
    chk("R5 no late entry after abort", {1'b0, mode_stat}, 8'h01);
  endtask

  task automatic t_wake();
    logic [7:0] d;
    do_reset();
    wr(2'd0, 8'h20);
    wr(2'd1, 8'h40); cyc(1);
    sleep_pulse(1'b0);
    chk("R6 low-power wait entered", {1'b0, mode_stat}, 8'h08);
    irq_pulse();
    chk("R6 wait wakes to low-power run", {1'b0, mode_stat}, 8'h04);
    irq_pulse();
    chk("R6 irq in low-power run without policy", {1'b0, mode_stat}, 8'h04);
    wr(2'd1, 8'hC0); cyc(1);
    sleep_pulse(1'b0);
    chk("R6 wait again", {1'b0, mode_stat}, 8'h08);
    irq_pulse();
    chk("R6 wait with policy wakes to run", {1'b0, mode_stat}, 8'h01);
    rd(2'd1, d); chk("R6 run field cleared on wake", d, 8'h80);
    wr(2'd1, 8'hC0); cyc(1);
    chk("R3 low-power run with policy", {1'b0, mode_stat}, 8'h04);
    irq_pulse();
    chk("R6 low-power run irq with policy", {1'b0, mode_stat}, 8'h01);
  endtask

  task automatic t_lpstop();
    do_reset();
    wr(2'd0, 8'h20);
    wr(2'd1, 8'h02);
    sleep_pulse(1'b1); cyc(2);
    chk("R4 low-power stop from run", {1'b0, mode_stat}, 8'h10);
    irq_pulse();
    chk("R7 from run wakes to run", {1'b0, mode_stat}, 8'h01);
    wr(2'd1, 8'h40); cyc(1);
    sleep_pulse(1'b1); cyc(2);
    chk("R4 low-power stop from low-power run", {1'b0, mode_stat}, 8'h10);
    irq_pulse();
    chk("R7 wakes to low-power run", {1'b0, mode_stat}, 8'h04);
    wr(2'd1, 8'hC0); cyc(1);
    sleep_pulse(1'b1); cyc(2);
    irq = 1'b1; @(posedge clk); @(negedge clk); irq = 1'b0;
    chk("R7 policy set wakes to run", {1'b0, mode_stat}, 8'h01);
  endtask

  task automatic t_debug();
    logic [7:0] d;
    do_reset();
    wr(2'd0, 8'h2A);
    dbg_en = 1'b1;
    sleep_pulse(1'b1); cyc(3);
    chk("R9 normal stop hidden", {1'b0, mode_stat}, 8'h01);
    rd(2'd3, d); chk("R9 status reg hidden", d, 8'h01);
    irq_pulse();
    wr(2'd1, 8'h02); sleep_pulse(1'b1); cyc(3);
    chk("R9 low-power stop hidden", {1'b0, mode_stat}, 8'h01);
    irq_pulse();
    wr(2'd1, 8'h03); sleep_pulse(1'b1); cyc(3);
    chk("R9 leak stop shown in debug", {1'b0, mode_stat}, 8'h20);
    irq_pulse();
    dbg_en = 1'b0;
    chk("R9 back to run", {1'b0, mode_stat}, 8'h01);
  endtask

  task automatic t_sub();
    logic [7:0] d;
    do_reset();
    wr(2'd2, 8'h21); rd(2'd2, d); chk("R10 submode 1 with brown-out off", d, 8'h21);
    wr(2'd2, 8'h06); rd(2'd2, d); chk("R10 reserved submode dropped", d, 8'h01);
    wr(2'd2, 8'hFF); rd(2'd2, d); chk("R10 masked bits", d, 8'h21);
    wr(2'd2, 8'h00); rd(2'd2, d); chk("R10 submode 0", d, 8'h00);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    t_reset();
    t_perm();
    t_stop_codes();
    t_run();
    t_entry();
    t_abort();
    t_wake();
    t_lpstop();
    t_debug();
    t_sub();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule